// File: doc/BRIEF.md
# Running-Mean DC Removal Filter

This block takes a stream of signed samples, one per clock when `valid_i` is high, and removes their DC level. The DC estimate is the mean of the most recent N accepted samples, which is the same as an FIR filter with every coefficient equal to 1/N. It is not built with N taps. A single accumulator adds each new sample and subtracts the sample that drops out of an N-deep shift line. Because N is a power of two, the division becomes a right shift. The estimate is then subtracted from the sample taken from the middle of the shift line, so that the sample lines up with the centre of the averaging window.

The window has to be long, around a thousand samples or more, so that only DC is removed and the passband is left alone. The default is N = 1024. Samples are two's complement. The output is one bit wider than the input, so the difference cannot wrap.

Top module: `dc_remove_ma`

## Requirements
- R1: While `rst_ni` is low, `valid_o` and `data_o` are 0. Reset clears the running sum, the shift line and the fill count, so a stream that starts after a mid-stream reset is processed as if no earlier samples existed.
- R2: `valid_o` stays low until N samples have been accepted since reset. It first rises in the cycle after the N-th accepted sample.
- R3: The running sum is DATA_W + log2(N) bits wide and never overflows. Long runs at the most positive and at the most negative input code give exact results.
- R4: Once the window is full, `valid_o` is high for exactly one cycle after each cycle with `valid_i` high. In every other cycle it is low.
- R5: For accepted sample n, `data_o` = x[n-N/2] - floor((x[n] + ... + x[n-N+1]) / N). It is a signed two's complement value, DATA_W+1 bits wide.
- R6: A cycle with `valid_i` low leaves the shift line, the running sum and the fill count unchanged. The results after a gap are the same as for the same samples sent back to back.
- R7: A constant input gives an output of 0 once the window holds only that constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample is valid this cycle |
| data_i | input | DATA_W | Input sample, signed |
| valid_o | output | 1 | Output sample is valid |
| data_o | output | DATA_W+1 | DC-removed sample, signed |

## Verification
Every result has a latency of exactly one clock. The sum update, the fill count and the output register all switch on the same edge that accepts the sample. The bench drives each input at a falling edge and samples `valid_o` and `data_o` at the next falling edge, so each check is tied to the single sample that caused it. Idle cycles are checked the same way: `valid_o` must be low one cycle after an idle input. The expected value comes from a shadow window of past samples kept in the bench, with the floor taken on the full-width sum.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_LOG2_N = 10;
endpackage

// File: rtl/dcr_tap_line.sv
module dcr_tap_line #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] mid_o,
  output logic [DATA_W-1:0] last_o
);
  localparam int unsigned MID = DEPTH / 2 - 1;

  logic [DATA_W-1:0] tap_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [DATA_W-1:0] src;
    if (g == 0) begin : g_head
      assign src = data_i;
    end else begin : g_body
      assign src = tap_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      tap_q[g] <= '0;
      else if (shift_i) tap_q[g] <= src;
    end
  end

  assign mid_o  = tap_q[MID];
  assign last_o = tap_q[DEPTH-1];
endmodule

// File: rtl/dcr_window_sum.sv
module dcr_window_sum #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LOG2_N = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic signed [DATA_W-1:0] new_i,
  input  logic signed [DATA_W-1:0] old_i,
  output logic signed [DATA_W-1:0] mean_o
);
  localparam int unsigned ACC_W = DATA_W + LOG2_N;
  localparam logic signed [ACC_W:0] STEP_MAX = (ACC_W+1)'((1 << DATA_W) - 1);

  logic signed [ACC_W-1:0] sum_q, sum_d;

  // new sample in, oldest sample out
  always_comb begin
    sum_d = sum_q;
    if (en_i) sum_d = sum_q + ACC_W'(new_i) - ACC_W'(old_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= sum_d;
  end

  // floor division by N: drop the low LOG2_N bits
  assign mean_o = sum_d[ACC_W-1:LOG2_N];

  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(sum_q));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (((ACC_W+1)'(sum_q) - (ACC_W+1)'($past(sum_q))) <= STEP_MAX) &&
             (((ACC_W+1)'(sum_q) - (ACC_W+1)'($past(sum_q))) >= -STEP_MAX));
endmodule

// File: rtl/dcr_fill_count.sv
module dcr_fill_count #(
  parameter int unsigned LOG2_N = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic full_o
);
  localparam int unsigned N     = 1 << LOG2_N;
  localparam int unsigned CNT_W = LOG2_N + 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (en_i && cnt_q != CNT_W'(N))     cnt_q <= cnt_q + 1'b1;
  end

  // high when the sample accepted this cycle completes (or follows) a full window
  assign full_o = (cnt_q >= CNT_W'(N - 1));

  assert_count_sat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(N));

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/dc_remove_ma.sv
module dc_remove_ma #(
  parameter int unsigned DATA_W = dcr_pkg::DEF_DATA_W,
  parameter int unsigned LOG2_N = dcr_pkg::DEF_LOG2_N
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] data_i,
  output logic                     valid_o,
  output logic signed [DATA_W:0]   data_o
);
  localparam int unsigned N     = 1 << LOG2_N;
  localparam int unsigned OUT_W = DATA_W + 1;

  logic [DATA_W-1:0]        mid_raw, last_raw;
  logic signed [DATA_W-1:0] mean;
  logic                     full;
  logic signed [OUT_W-1:0]  diff;

  dcr_tap_line #(.DATA_W(DATA_W), .DEPTH(N)) u_taps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(valid_i),
    .data_i (data_i),
    .mid_o  (mid_raw),
    .last_o (last_raw)
  );

  dcr_window_sum #(.DATA_W(DATA_W), .LOG2_N(LOG2_N)) u_sum (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .new_i (data_i),
    .old_i ($signed(last_raw)),
    .mean_o(mean)
  );

  dcr_fill_count #(.LOG2_N(LOG2_N)) u_fill (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .full_o(full)
  );

  assign diff = OUT_W'($signed(mid_raw)) - OUT_W'(mean);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i && full;
      if (valid_i) data_o <= diff;
    end
  end

  assert_valid_lag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));

  assert_hold_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(data_o));
endmodule

// File: tb/dc_remove_ma_tb.sv
module dc_remove_ma_tb;
  localparam int DW = 16;
  localparam int L  = 3;
  localparam int N  = 1 << L;
  localparam int H  = N / 2;
  localparam int NV = 24;

  // {idle cycles before sample, sample}
  localparam logic [35:0] VEC [NV] = '{
    {20'd0, 16'sd100}, {20'd0, 16'sd100}, {20'd0, 16'sd100}, {20'd0, 16'sd100},
    {20'd0, 16'sd100}, {20'd0, 16'sd100}, {20'd0, 16'sd100}, {20'd0, 16'sd100},
    {20'd0, 16'sd100}, {20'd0, 16'sd100}, {20'd0, 16'sd250}, {20'd0, -16'sd7},
    {20'd2, 16'sd3},   {20'd0, -16'sd1},  {20'd1, 16'sd400}, {20'd0, -16'sd900},
    {20'd0, 16'sd12},  {20'd3, 16'sd5},   {20'd0, -16'sd3},  {20'd0, 16'sd0},
    {20'd0, 16'sd1},   {20'd1, -16'sd2},  {20'd0, 16'sd77},  {20'd0, -16'sd31}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic signed [DW-1:0] data_i = '0;
  logic valid_o;
  logic signed [DW:0] data_o;

  int checks = 0, fails = 0;
  int hist [N];
  int fill = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  dc_remove_ma #(.DATA_W(DW), .LOG2_N(L)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .valid_o(valid_o), .data_o(data_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) hist[i] = 0;
    fill = 0;
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(input bit v, input int x, input bit is_const);
    int sum, exp_d;
    bit exp_v;
    valid_i = v;
    data_i  = DW'(x);
    exp_v = 1'b0;
    exp_d = 0;
    if (v) begin
      for (int i = N - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = x;
      if (fill < N) fill++;
      sum = 0;
      for (int i = 0; i < N; i++) sum += hist[i];
      exp_v = (fill >= N);
      exp_d = hist[H] - (sum >>> L);
    end
    @(negedge clk_i);
    check(v ? "R2/R4 valid" : "R6 idle valid", int'(valid_o), int'(exp_v));
    if (exp_v) begin
      check("R5 data", int'(data_o), exp_d);
      if (is_const) check("R7 const zero", int'(data_o), 0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni  = 1'b0;
    @(negedge clk_i);
    check("R1 reset valid", int'(valid_o), 0);
    check("R1 reset data", int'(data_o), 0);
    rst_ni = 1'b1;
    model_clear();
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk_i);
    check("R1 reset valid", int'(valid_o), 0);
    check("R1 reset data", int'(data_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table walk: R2 fill, R7 constant, R5 mixed, R6 gaps
    for (int k = 0; k < NV; k++) begin
      for (int g = 0; g < int'(VEC[k][35:16]); g++) step(1'b0, 0, 1'b0);
      step(1'b1, int'($signed(VEC[k][15:0])), k >= N - 1 && k < 10);
    end

    // R3: full-scale runs both ways
    for (int k = 0; k < 2 * N; k++) step(1'b1, 32767, k >= N);
    for (int k = 0; k < 2 * N; k++) step(1'b1, -32768, k >= N);
    for (int k = 0; k < H + 1; k++) step(1'b1, 32767, 1'b0);

    // R1: mid-stream reset restarts fill and clears the sum
    do_reset();
    for (int k = 0; k < N + 4; k++) step(1'b1, (k % 3) * 11 - 9, 1'b0);

    // R6: sparse stream equals dense stream on the same samples
    for (int k = 0; k < N; k++) begin
      step(1'b0, 0, 1'b0);
      step(1'b1, -5 * k, 1'b0);
    end

    // R7: negative constant
    for (int k = 0; k < 2 * N; k++) step(1'b1, -123, k >= N);
    step(1'b0, 0, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule